// File: doc/BRIEF.md
# Multi-Mode Vector Accumulator

This block holds a bank of 128 signed 32-bit words. On every clock edge it may update that bank from a 128-lane product vector. A 4-bit operation code picks the update. It can add the products, overwrite the bank with them, or clear it. It can add the products and then add one broadcast 32-bit bias to every word, either on top of the old contents or in place of them. It can take a signed maximum across the old word, the product and the bias, or across the product and the bias only. It can also rebuild part of the bank from a decimated view of the product vector. The whole bank is always visible on the output, so the next pipeline stage can read it directly.

In the decimated mode the product vector is seen as a matrix whose rows hold 8, 16, 32 or 64 elements. Alternate columns can be dropped, keeping the even ones or the odd ones. The even columns can also be kept and each written twice, which restores the row width. Alternate rows can be dropped in the same way. The surviving elements, read in row-major order, are written to consecutive words. The write starts at a quarter boundary of the bank, and the words it does not reach keep their values.

Top module: `vacc_core`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) sets all 128 words to zero, whatever the operation code.
- R2: Operation code 0, and any code from 9 to 15, leaves every word unchanged.
- R3: Code 1 sets acc[i] = acc[i] + prod[i] for every lane, wrapping modulo 2^32.
- R4: Code 2 sets acc[i] = prod[i] for every lane.
- R5: Code 3 sets every word to zero.
- R6: Code 4 sets acc[i] = acc[i] + prod[i] + bias, wrapping modulo 2^32.
- R7: Code 5 sets acc[i] = prod[i] + bias, wrapping modulo 2^32.
- R8: Code 6 sets acc[i] to the signed maximum of acc[i], prod[i] and bias.
- R9: Code 7 sets acc[i] to the signed maximum of prod[i] and bias, ignoring the old word.
- R10: With code 8 the product is read as rows of 8 << `row_sel` elements, in row-major order. `col_mode` selects the columns: 0 keeps all columns, 1 keeps the even ones, 2 keeps the odd ones, and 3 keeps the even ones and writes each of them twice.
- R11: With code 8, `row_mode` selects the rows: 0 keeps all rows, 1 keeps the even ones, 2 keeps the odd ones, and 3 behaves as 0.
- R12: With code 8 the kept elements go in order to words start, start+1, and so on, where start = 32 × `stride_slot`. The write wraps from word 127 to word 0 and covers N = 128 >> (c + r) words. Here c is 1 when `col_mode` is 1 or 2, and r is 1 when `row_mode` is 1 or 2. All other words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates take effect on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 4 | Operation code |
| prod_vec | input | 4096 | Product vector; lane i is bits [32i+31:32i] |
| bias | input | 32 | Broadcast bias value |
| row_sel | input | 2 | Row length select for the decimated mode (8 << row_sel) |
| col_mode | input | 2 | Column decimation select |
| row_mode | input | 2 | Row decimation select |
| stride_slot | input | 2 | Start quarter for the decimated write |
| acc_vec | output | 4096 | Accumulator contents; word i is bits [32i+31:32i] |

## Verification
The arithmetic modes are driven with lane values spread over the full signed range, so that a signed comparison and an unsigned one pick different winners. The additive modes also run on values near the positive limit, which shows whether the sums wrap. The maximum modes run with a negative bias, a zero bias and a large positive bias, which shows whether the bias, the product and the old word each take part. The decimated mode is swept over all 256 combinations of row length, column mode, row mode and start quarter. Each sweep point preloads a distinct background pattern, which shows whether the source order is right, whether the write length is right, whether it wraps at the top of the bank, and whether the words outside the range are left untouched.

// File: rtl/vacc_pkg.sv
// Package: shared operation codes and decimation mode encodings for the
// vector accumulator. Assumes a 4-bit operation code and 2-bit mode fields.
package vacc_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_ACC        = 4'd1,
        OP_FIRST      = 4'd2,
        OP_CLEAR      = 4'd3,
        OP_ADDB       = 4'd4,
        OP_ADDB_FIRST = 4'd5,
        OP_MAX        = 4'd6,
        OP_MAX_FIRST  = 4'd7,
        OP_STRIDE     = 4'd8
    } vacc_op_e;

    localparam logic [1:0] COL_ALL    = 2'd0;
    localparam logic [1:0] COL_EVEN   = 2'd1;
    localparam logic [1:0] COL_ODD    = 2'd2;
    localparam logic [1:0] COL_EXPAND = 2'd3;

    localparam logic [1:0] ROW_ALL  = 2'd0;
    localparam logic [1:0] ROW_EVEN = 2'd1;
    localparam logic [1:0] ROW_ODD  = 2'd2;

endpackage

// File: rtl/vacc_lane_alu.sv
// Module: per-lane next-value logic. It combines the old word, the product,
// the broadcast bias and the decimated-mode source word according to the
// operation code. Assumes two's complement words; sums wrap and maxima are signed.
module vacc_lane_alu
    import vacc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] old_w,
    input  logic [W-1:0] prod_w,
    input  logic [W-1:0] bias_w,
    input  logic         stride_we,
    input  logic [W-1:0] stride_w,
    output logic [W-1:0] next_w
);

    // Signed maximum of two words.
    function automatic logic [W-1:0] smax(input logic [W-1:0] a, input logic [W-1:0] b);
        return ($signed(a) >= $signed(b)) ? a : b;
    endfunction

    logic [W-1:0] sum_acc;
    logic [W-1:0] max_pb;

    // Shared adder and comparator terms.
    always_comb begin
        sum_acc = old_w + prod_w;
        max_pb  = smax(prod_w, bias_w);
    end

    // Select the next word by operation code.
    always_comb begin
        case (op)
            OP_ACC:        next_w = sum_acc;
            OP_FIRST:      next_w = prod_w;
            OP_CLEAR:      next_w = '0;
            OP_ADDB:       next_w = sum_acc + bias_w;
            OP_ADDB_FIRST: next_w = prod_w + bias_w;
            OP_MAX:        next_w = smax(old_w, max_pb);
            OP_MAX_FIRST:  next_w = max_pb;
            OP_STRIDE:     next_w = stride_we ? stride_w : old_w;
            default:       next_w = old_w;
        endcase
    end

endmodule

// File: rtl/vacc_stride_map.sv
// Module: works out, for each accumulator word, whether the decimated write
// reaches it and which product lane feeds it. Assumes LANES is a multiple of
// 128 so that every row length divides it; the start is a quarter of LANES.
module vacc_stride_map
    import vacc_pkg::*;
#(
    parameter int LANES = 128,
    parameter int IDXW  = $clog2(LANES)
) (
    input  logic [1:0]                   row_sel,
    input  logic [1:0]                   col_mode,
    input  logic [1:0]                   row_mode,
    input  logic [1:0]                   slot,
    output logic [LANES-1:0]             we,
    output logic [LANES-1:0][IDXW-1:0]   src
);

    localparam int unsigned QUARTER = LANES / 4;

    logic        col_cut;
    logic        row_cut;
    int unsigned start;
    int unsigned nwords;
    int unsigned lg_row;
    int unsigned lg_out;

    // Terms shared by every lane: write length, start word and row geometry.
    always_comb begin
        col_cut = (col_mode == COL_EVEN) || (col_mode == COL_ODD);
        row_cut = (row_mode == ROW_EVEN) || (row_mode == ROW_ODD);
        start   = 32'(slot) * QUARTER;
        nwords  = 32'(LANES) >> (32'(col_cut) + 32'(row_cut));
        lg_row  = 32'd3 + 32'(row_sel);
        lg_out  = lg_row - 32'(col_cut);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        int unsigned pos;
        int unsigned orow;
        int unsigned ocol;
        int unsigned srow;
        int unsigned scol;

        // Inverse map: output position of this word, then its source row and column.
        always_comb begin
            pos  = (32'(k) + 32'(LANES) - start) % 32'(LANES);
            orow = pos >> lg_out;
            ocol = pos & ((32'd1 << lg_out) - 32'd1);
            case (row_mode)
                ROW_EVEN: srow = orow << 1;
                ROW_ODD:  srow = (orow << 1) + 32'd1;
                default:  srow = orow;
            endcase
            case (col_mode)
                COL_EVEN:   scol = ocol << 1;
                COL_ODD:    scol = (ocol << 1) + 32'd1;
                COL_EXPAND: scol = ocol & ~32'd1;
                default:    scol = ocol;
            endcase
        end

        assign we[k]  = (pos < nwords);
        assign src[k] = IDXW'((srow << lg_row) | scol);
    end

endmodule

// File: rtl/vacc_core.sv
// Module: multi-mode vector accumulator. It holds LANES words of W bits and
// updates all of them on one rising edge from the product vector, the bias and
// the decimation settings. Assumes inputs are stable around the clock edge.
module vacc_core
    import vacc_pkg::*;
#(
    parameter int LANES = 128,
    parameter int W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           op,
    input  logic [LANES*W-1:0]   prod_vec,
    input  logic [W-1:0]         bias,
    input  logic [1:0]           row_sel,
    input  logic [1:0]           col_mode,
    input  logic [1:0]           row_mode,
    input  logic [1:0]           stride_slot,
    output logic [LANES*W-1:0]   acc_vec
);

    localparam int IDXW = $clog2(LANES);

    logic [LANES-1:0][W-1:0]    acc_q;
    logic [LANES-1:0][W-1:0]    acc_d;
    logic [LANES-1:0][W-1:0]    prod_l;
    logic [LANES-1:0]           map_we;
    logic [LANES-1:0][IDXW-1:0] map_src;

    assign prod_l  = prod_vec;
    assign acc_vec = acc_q;

    vacc_stride_map #(
        .LANES (LANES),
        .IDXW  (IDXW)
    ) u_map (
        .row_sel  (row_sel),
        .col_mode (col_mode),
        .row_mode (row_mode),
        .slot     (stride_slot),
        .we       (map_we),
        .src      (map_src)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_alu
        vacc_lane_alu #(
            .W (W)
        ) u_alu (
            .op        (op),
            .old_w     (acc_q[k]),
            .prod_w    (prod_l[k]),
            .bias_w    (bias),
            .stride_we (map_we[k]),
            .stride_w  (prod_l[map_src[k]]),
            .next_w    (acc_d[k])
        );
    end

    // Accumulator register: reset to zero, otherwise take every lane's next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/vacc_core_chk.sv
// Module: property checker for the vector accumulator, attached by bind.
// Assumes the same parameters as the instance it watches.
module vacc_core_chk
    import vacc_pkg::*;
#(
    parameter int LANES = 128,
    parameter int W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           op,
    input logic [LANES*W-1:0]   prod_vec,
    input logic [W-1:0]         bias,
    input logic [1:0]           row_mode,
    input logic [1:0]           col_mode,
    input logic [1:0]           stride_slot,
    input logic [LANES*W-1:0]   acc_vec
);

    localparam int HALF = LANES * W / 2;

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> acc_vec == '0); // R1

    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP) |=> $stable(acc_vec)); // R2

    AST_ACC_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACC) |=> acc_vec[W-1:0] == $past(acc_vec[W-1:0]) + $past(prod_vec[W-1:0])); // R3

    AST_FIRST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FIRST) |=> acc_vec == $past(prod_vec)); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> acc_vec == '0); // R5

    AST_MAXF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MAX_FIRST) |=> $signed(acc_vec[W-1:0]) >= $signed($past(bias))); // R9

    AST_STRIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STRIDE && col_mode == COL_EVEN && row_mode == ROW_ALL && stride_slot == 2'd0)
        |=> acc_vec[LANES*W-1:HALF] == $past(acc_vec[LANES*W-1:HALF])); // R12

endmodule

bind vacc_core vacc_core_chk #(
    .LANES (LANES),
    .W     (W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .prod_vec    (prod_vec),
    .bias        (bias),
    .row_mode    (row_mode),
    .col_mode    (col_mode),
    .stride_slot (stride_slot),
    .acc_vec     (acc_vec)
);

// File: tb/tb_vacc_core.sv
// Bench: drives every mode, computes expected words arithmetically and sweeps
// every decimation setting.
module tb_vacc_core;

    localparam int L = 128;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      op = 4'd0;
    logic [L*32-1:0] prod_vec = '0;
    logic [31:0]     bias = '0;
    logic [1:0]      row_sel = '0;
    logic [1:0]      col_mode = '0;
    logic [1:0]      row_mode = '0;
    logic [1:0]      stride_slot = '0;
    logic [L*32-1:0] acc_vec;

    logic [31:0] pv  [L];
    logic [31:0] exp_acc [L];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vacc_core dut (
        .clk (clk), .rst_n (rst_n), .op (op), .prod_vec (prod_vec), .bias (bias),
        .row_sel (row_sel), .col_mode (col_mode), .row_mode (row_mode),
        .stride_slot (stride_slot), .acc_vec (acc_vec)
    );

    function automatic logic [31:0] pat(int i, int s);
        return (32'(i) * 32'h9E3779B1) ^ (32'(s) * 32'h7F4A7C15) ^ (32'(i) << 8);
    endfunction

    function automatic logic [31:0] smax(logic [31:0] a, logic [31:0] b);
        return ($signed(a) >= $signed(b)) ? a : b;
    endfunction

    task automatic fill(int s);
        for (int i = 0; i < L; i++) pv[i] = pat(i, s);
    endtask

    // Drive one operation at a falling edge and return at the next falling edge.
    task automatic apply(logic [3:0] code);
        for (int i = 0; i < L; i++) prod_vec[i*32 +: 32] = pv[i];
        op = code;
        @(negedge clk);
        op = 4'd0;
    endtask

    task automatic check_all(string tag);
        int bad = -1;
        for (int i = 0; i < L; i++)
            if (bad < 0 && acc_vec[i*32 +: 32] !== exp_acc[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s word %0d: got %h expected %h", tag, bad,
                     acc_vec[bad*32 +: 32], exp_acc[bad]);
        end
    endtask

    // Forward model of the decimated write: walk kept rows and columns in order.
    task automatic model_stride(int rs, int cm, int rm, int slot);
        int rlen = 8 << rs;
        int j = 0;
        for (int row = 0; row < L / rlen; row++) begin
            if (rm == 1 && (row % 2) == 1) continue;
            if (rm == 2 && (row % 2) == 0) continue;
            for (int col = 0; col < rlen; col++) begin
                if ((cm == 1 || cm == 3) && (col % 2) == 1) continue;
                if (cm == 2 && (col % 2) == 0) continue;
                for (int d = 0; d < ((cm == 3) ? 2 : 1); d++) begin
                    exp_acc[(slot * 32 + j) % L] = pv[row * rlen + col];
                    j++;
                end
            end
        end
    endtask

    initial begin
        for (int i = 0; i < L; i++) exp_acc[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R4: overwrite with products
        fill(1); apply(4'd2);
        for (int i = 0; i < L; i++) exp_acc[i] = pv[i];
        check_all("R4 first");

        // R3: accumulate with values near the positive limit, so sums wrap
        for (int i = 0; i < L; i++) pv[i] = 32'h7FFF_FF00 + 32'(i * 3);
        apply(4'd1);
        for (int i = 0; i < L; i++) exp_acc[i] = exp_acc[i] + pv[i];
        check_all("R3 acc wrap");
        fill(2); apply(4'd1);
        for (int i = 0; i < L; i++) exp_acc[i] = exp_acc[i] + pv[i];
        check_all("R3 acc spread");

        // R2: no-op code 0 and every unused code
        fill(3); apply(4'd0);
        check_all("R2 nop");
        for (int c = 9; c < 16; c++) begin
            fill(c); apply(4'(c));
            check_all("R2 unused code");
        end

        // R6 / R7: bias variants
        fill(4); bias = 32'h8000_0123; apply(4'd4);
        for (int i = 0; i < L; i++) exp_acc[i] = exp_acc[i] + pv[i] + bias;
        check_all("R6 add bias");
        fill(5); bias = 32'hFFFF_FFF0; apply(4'd5);
        for (int i = 0; i < L; i++) exp_acc[i] = pv[i] + bias;
        check_all("R7 add bias first");

        // R8 / R9: signed maxima with negative, zero and large positive bias
        for (int b = 0; b < 3; b++) begin
            bias = (b == 0) ? 32'hFFFF_FFFB : (b == 1) ? 32'h0 : 32'h7000_0000;
            fill(6 + b); apply(4'd6);
            for (int i = 0; i < L; i++) exp_acc[i] = smax(smax(exp_acc[i], pv[i]), bias);
            check_all("R8 max");
            fill(20 + b); apply(4'd7);
            for (int i = 0; i < L; i++) exp_acc[i] = smax(pv[i], bias);
            check_all("R9 max first");
        end

        // R5: clear
        fill(30); apply(4'd2);
        for (int i = 0; i < L; i++) exp_acc[i] = pv[i];
        apply(4'd3);
        for (int i = 0; i < L; i++) exp_acc[i] = '0;
        check_all("R5 clear");

        // R1: reset wins over an accumulate
        fill(31); apply(4'd2);
        rst_n = 1'b0; op = 4'd1; @(negedge clk); op = 4'd0; rst_n = 1'b1;
        for (int i = 0; i < L; i++) exp_acc[i] = '0;
        check_all("R1 reset over acc");

        // R10, R11, R12: all decimation settings over a fresh background
        for (int rs = 0; rs < 4; rs++)
            for (int cm = 0; cm < 4; cm++)
                for (int rm = 0; rm < 4; rm++)
                    for (int sl = 0; sl < 4; sl++) begin
                        int cfg = rs * 64 + cm * 16 + rm * 4 + sl;
                        fill(1000 + cfg); apply(4'd2);
                        for (int i = 0; i < L; i++) exp_acc[i] = pv[i];
                        row_sel = 2'(rs); col_mode = 2'(cm);
                        row_mode = 2'(rm); stride_slot = 2'(sl);
                        fill(5000 + cfg); apply(4'd8);
                        model_stride(rs, cm, rm, sl);
                        check_all("R10,R11,R12 stride");
                    end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule